// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transceiver

This block moves characters between a parallel register-style interface and a pair of asynchronous serial lines. On the transmit side a one-character holding stage feeds a shifter. The shifter sends a low start bit, the data bits least significant first, an optional parity bit and one or two high stop bits. On the receive side the line is synchronised and oversampled. Each bit is decided by a majority of three samples taken around its middle, and the finished character is placed in a one-deep buffer together with its error flags.

The frame shape is chosen at run time. It can carry 5 to 9 data bits, no/even/odd parity and one or two stop bits. A 12-bit divisor sets the bit rate, and a double-speed mode halves the oversampling ratio. The ninth data bit travels on its own pins, apart from the 8-bit data bus. Three interrupt outputs each gate one status flag with an enable input. The bit period is 16*(divisor+1) clock cycles in normal mode and 8*(divisor+1) in double-speed mode. For example, a 16 MHz clock with divisor 103 gives about 9600 baud.

Top module: `serial_xcvr`

## Requirements
- R1: After reset, txd is high, tx_empty is 1, and rx_full, tx_done, frame_err, overrun_err, parity_err and all three interrupt outputs are 0.
- R2: A transmitted frame begins with one low start bit. The data bits follow least significant first, and each bit lasts 16*(baud_div+1) clocks when fast_mode is 0.
- R3: par_mode 2'b00 and 2'b01 send and expect no parity bit. 2'b10 adds an even parity bit and 2'b11 an odd parity bit, placed right after the data bits.
- R4: two_stop=1 sends two high stop bits and two_stop=0 sends one. The receiver checks only the first stop bit: frame_err is 1 for a character whose first stop bit was sampled low, and a low second stop bit has no effect.
- R5: When fast_mode is 1, every bit on both lines lasts 8*(baud_div+1) clocks.
- R6: A tx_write while tx_empty is 1 is taken, and tx_empty reads 0 in the cycle after. A tx_write while tx_empty is 0 is ignored and produces no frame. tx_done becomes 1 when a frame ends with no character waiting, and the next accepted tx_write clears it.
- R7: A received character sets rx_full and appears on rx_data/rx_bit8, masked to the selected size. rx_read clears rx_full.
- R8: If a character completes while rx_full is 1 and no rx_read is given, overrun_err becomes 1 and the buffered character is kept unchanged. rx_read clears overrun_err.
- R9: parity_err is 1 for a received character whose parity bit does not match the selected even/odd mode, and 0 when it matches or parity is off.
- R10: A low pulse on rxd that is high again by the middle of the would-be start bit is rejected as a glitch, and no character is produced.
- R11: irq_rx = rx_full AND irq_en_rx, irq_txc = tx_done AND irq_en_txc, irq_empty = tx_empty AND irq_en_empty.
- R12: size_code selects the data width: 3'b000=5, 3'b001=6, 3'b010=7, 3'b011=8 and 3'b111=9 bits, with any other code giving 8. In 9-bit mode tx_bit8 is sent as the ninth data bit and the received ninth bit appears on rx_bit8, which is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| baud_div | input | 12 | Bit-rate divisor |
| fast_mode | input | 1 | Halve the oversampling ratio |
| size_code | input | 3 | Data width code |
| par_mode | input | 2 | Parity mode code |
| two_stop | input | 1 | Send two stop bits |
| irq_en_rx | input | 1 | Enable for the receive interrupt |
| irq_en_txc | input | 1 | Enable for the transmit-complete interrupt |
| irq_en_empty | input | 1 | Enable for the buffer-empty interrupt |
| tx_write | input | 1 | Write strobe for a transmit character |
| tx_data | input | 8 | Transmit data bits 7..0 |
| tx_bit8 | input | 1 | Ninth transmit data bit |
| rx_read | input | 1 | Read strobe that frees the receive buffer |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| rx_data | output | 8 | Received data bits 7..0 |
| rx_bit8 | output | 1 | Ninth received data bit |
| rx_full | output | 1 | Unread received character present |
| tx_done | output | 1 | Transmission finished, nothing pending |
| tx_empty | output | 1 | Transmit holding stage can take a write |
| frame_err | output | 1 | First stop bit of the held character was low |
| overrun_err | output | 1 | A character was lost to an unread buffer |
| parity_err | output | 1 | Parity mismatch on the held character |
| irq_rx | output | 1 | Receive interrupt |
| irq_txc | output | 1 | Transmit-complete interrupt |
| irq_empty | output | 1 | Buffer-empty interrupt |

## Verification
The embedded assertions check rules that apply every cycle. A start bit must follow each shifter load, and writes into a full holding stage must leave it untouched. Overrun must keep the buffer intact and never appear without a full buffer, a read must clear the full flag, and the rate tick must be spaced by the divisor. Only the bench scenarios can show whole-frame behaviour: bit order, bit duration in both speed modes, parity and stop-bit layout for each frame shape, the handling of framing and parity errors, and glitch rejection. The bench receives every transmitted frame by mid-bit sampling and compares it against a queue of expected characters.

// File: rtl/serial_pkg.sv
package serial_pkg;

    localparam int DATA_MAX = 9;
    localparam int FRAME_W  = 1 + DATA_MAX + 1 + 2;

    typedef enum logic [1:0] {
        PAR_NONE = 2'b00,
        PAR_RSVD = 2'b01,
        PAR_EVEN = 2'b10,
        PAR_ODD  = 2'b11
    } par_mode_e;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_START,
        RX_BITS,
        RX_STOP
    } rx_state_e;

    typedef struct packed {
        logic [2:0] size_code;
        par_mode_e  par;
        logic       two_stop;
    } frame_cfg_t;

    typedef struct packed {
        logic [DATA_MAX-1:0] data;
        logic                frame_err;
        logic                par_err;
    } rx_char_t;

    // Number of data bits selected by a size code.
    function automatic logic [3:0] data_bits(input logic [2:0] code);
        case (code)
            3'b000:  data_bits = 4'd5;
            3'b001:  data_bits = 4'd6;
            3'b010:  data_bits = 4'd7;
            3'b111:  data_bits = 4'd9;
            default: data_bits = 4'd8;
        endcase
    endfunction

    function automatic logic [DATA_MAX-1:0] data_mask(input logic [3:0] n);
        data_mask = 9'h1FF >> (4'd9 - n);
    endfunction

    // Parity bit for the active data bits; the low mode bit selects odd.
    function automatic logic parity_of(input logic [DATA_MAX-1:0] d,
                                       input logic [3:0] n,
                                       input par_mode_e m);
        parity_of = (^(d & data_mask(n))) ^ m[0];
    endfunction

endpackage

// File: rtl/serial_baud.sv
module serial_baud #(
    parameter int DIV_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] divisor,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else if (cnt >= divisor) begin
            cnt  <= '0;
            tick <= 1'b1;
        end else begin
            cnt  <= cnt + {{(DIV_W-1){1'b0}}, 1'b1};
            tick <= 1'b0;
        end
    end

    // R2 / R5: ticks are spaced by divisor+1 clocks
    assert_tick_spacing_R2: assert property (@(posedge clk) disable iff (rst)
        (tick && divisor != '0 && $stable(divisor)) |=> !tick);

endmodule

// File: rtl/serial_tx.sv
module serial_tx
    import serial_pkg::*;
#(
    parameter int SUB_W = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                tick,
    input  logic [SUB_W-1:0]    osr_last,
    input  frame_cfg_t          cfg,
    input  logic                wr,
    input  logic [DATA_MAX-1:0] wdata,
    output logic                txd,
    output logic                empty,
    output logic                done
);
    localparam logic [SUB_W-1:0] SUB_ONE = SUB_W'(1);

    logic [DATA_MAX-1:0] hold_data;
    logic                hold_full;
    logic [FRAME_W-1:0]  shreg;
    logic [FRAME_W-1:0]  frame;
    logic [3:0]          bits_left;
    logic [3:0]          frame_len;
    logic [3:0]          nbits;
    logic [SUB_W-1:0]    sub;
    logic                busy;
    logic                wr_ok;
    logic                load;

    assign wr_ok = wr && !hold_full;
    assign load  = !busy && hold_full;

    always_comb begin
        nbits = data_bits(cfg.size_code);
        frame = '1;
        frame[0] = 1'b0;
        for (int i = 0; i < DATA_MAX; i++) begin
            if (4'(i) < nbits) frame[i+1] = hold_data[i];
        end
        if (cfg.par[1]) frame[4'd1 + nbits] = parity_of(hold_data, nbits, cfg.par);
        frame_len = 4'd1 + nbits + {3'b000, cfg.par[1]} + 4'd1 + {3'b000, cfg.two_stop};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_data <= '0;
            hold_full <= 1'b0;
            shreg     <= '1;
            bits_left <= '0;
            sub       <= '0;
            busy      <= 1'b0;
            done      <= 1'b0;
        end else begin
            if (wr_ok) begin
                hold_data <= wdata;
                hold_full <= 1'b1;
                done      <= 1'b0;
            end
            if (load) begin
                busy      <= 1'b1;
                shreg     <= frame;
                bits_left <= frame_len;
                sub       <= '0;
                hold_full <= 1'b0;
            end else if (busy && tick) begin
                if (sub == osr_last) begin
                    sub       <= '0;
                    shreg     <= {1'b1, shreg[FRAME_W-1:1]};
                    bits_left <= bits_left - 4'd1;
                    if (bits_left == 4'd1) begin
                        busy <= 1'b0;
                        if (!hold_full && !wr_ok) done <= 1'b1;
                    end
                end else begin
                    sub <= sub + SUB_ONE;
                end
            end
        end
    end

    assign txd   = busy ? shreg[0] : 1'b1;
    assign empty = !hold_full;

    // R2: a shifter load is followed by the start bit on the line
    assert_load_start_low_R2: assert property (@(posedge clk) disable iff (rst)
        load |=> (txd == 1'b0));

    // R6: a write into a full holding stage leaves it untouched
    assert_write_ignored_R6: assert property (@(posedge clk) disable iff (rst)
        (wr && hold_full && !load) |=> $stable(hold_data));

endmodule

// File: rtl/serial_rx.sv
module serial_rx
    import serial_pkg::*;
#(
    parameter int SUB_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic [SUB_W-1:0] osr_last,
    input  logic [SUB_W-1:0] mid,
    input  frame_cfg_t       cfg,
    input  logic             rxd,
    input  logic             rd,
    output rx_char_t         char_q,
    output logic             done,
    output logic             ovr
);
    localparam logic [SUB_W-1:0] SUB_ONE = SUB_W'(1);

    rx_state_e        state;
    logic             sync_a, line;
    logic [SUB_W-1:0] sub;
    logic [SUB_W-1:0] mid_lo, mid_hi;
    logic [3:0]       idx, last_idx, nbits;
    logic             s0, s1, vote;
    logic [9:0]       acc;
    logic             finish;
    rx_char_t         next_char;

    assign mid_lo   = mid - SUB_ONE;
    assign mid_hi   = mid + SUB_ONE;
    assign nbits    = data_bits(cfg.size_code);
    assign last_idx = nbits + {3'b000, cfg.par[1]} - 4'd1;
    assign vote     = (s0 & s1) | (s0 & line) | (s1 & line);
    assign finish   = tick && (state == RX_STOP) && (sub == mid_hi);

    always_comb begin
        next_char.data      = acc[DATA_MAX-1:0] & data_mask(nbits);
        next_char.frame_err = !vote;
        next_char.par_err   = cfg.par[1] &&
            (acc[nbits] != parity_of(acc[DATA_MAX-1:0], nbits, cfg.par));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_a <= 1'b1;
            line   <= 1'b1;
        end else begin
            sync_a <= rxd;
            line   <= sync_a;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= RX_IDLE;
            sub    <= '0;
            idx    <= '0;
            s0     <= 1'b1;
            s1     <= 1'b1;
            acc    <= '0;
            char_q <= '0;
            done   <= 1'b0;
            ovr    <= 1'b0;
        end else begin
            if (tick) begin
                if (state == RX_IDLE) begin
                    if (!line) begin
                        state <= RX_START;
                        sub   <= '0;
                    end
                end else begin
                    sub <= (sub == osr_last) ? '0 : sub + SUB_ONE;
                    if (sub == mid_lo) s0 <= line;
                    if (sub == mid)    s1 <= line;
                    if (sub == mid_hi) begin
                        case (state)
                            RX_START: if (vote) state <= RX_IDLE;
                            RX_BITS:  acc[idx] <= vote;
                            RX_STOP:  state <= RX_IDLE;
                            default:  ;
                        endcase
                    end else if (sub == osr_last) begin
                        case (state)
                            RX_START: begin
                                state <= RX_BITS;
                                idx   <= '0;
                            end
                            RX_BITS: begin
                                if (idx == last_idx) state <= RX_STOP;
                                else                 idx   <= idx + 4'd1;
                            end
                            default: ;
                        endcase
                    end
                end
            end
            if (finish) begin
                if (done && !rd) begin
                    ovr <= 1'b1;
                end else begin
                    char_q <= next_char;
                    done   <= 1'b1;
                    ovr    <= 1'b0;
                end
            end else if (rd) begin
                done <= 1'b0;
                ovr  <= 1'b0;
            end
        end
    end

    // R8: on overrun the buffered character is preserved
    assert_overrun_keeps_R8: assert property (@(posedge clk) disable iff (rst)
        (finish && done && !rd) |=> $stable(char_q));

    // R8: overrun never stands without an unread character
    assert_overrun_with_full_R8: assert property (@(posedge clk) disable iff (rst)
        ovr |-> done);

    // R7: a read without a new completion empties the buffer
    assert_read_clears_R7: assert property (@(posedge clk) disable iff (rst)
        (rd && !finish) |=> !done);

endmodule

// File: rtl/serial_xcvr.sv
module serial_xcvr
    import serial_pkg::*;
#(
    parameter int DIV_W    = 12,
    parameter int OSR_NORM = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] baud_div,
    input  logic             fast_mode,
    input  logic [2:0]       size_code,
    input  logic [1:0]       par_mode,
    input  logic             two_stop,
    input  logic             irq_en_rx,
    input  logic             irq_en_txc,
    input  logic             irq_en_empty,
    input  logic             tx_write,
    input  logic [7:0]       tx_data,
    input  logic             tx_bit8,
    input  logic             rx_read,
    input  logic             rxd,
    output logic             txd,
    output logic [7:0]       rx_data,
    output logic             rx_bit8,
    output logic             rx_full,
    output logic             tx_done,
    output logic             tx_empty,
    output logic             frame_err,
    output logic             overrun_err,
    output logic             parity_err,
    output logic             irq_rx,
    output logic             irq_txc,
    output logic             irq_empty
);
    localparam int OSR_DBL = OSR_NORM / 2;
    localparam int SUB_W   = $clog2(OSR_NORM);

    logic             tick;
    logic [SUB_W-1:0] osr_last;
    logic [SUB_W-1:0] mid;
    frame_cfg_t       cfg;
    rx_char_t         rx_char;

    assign osr_last      = fast_mode ? SUB_W'(OSR_DBL - 1) : SUB_W'(OSR_NORM - 1);
    assign mid           = fast_mode ? SUB_W'(OSR_DBL / 2) : SUB_W'(OSR_NORM / 2);
    assign cfg.size_code = size_code;
    assign cfg.par       = par_mode_e'(par_mode);
    assign cfg.two_stop  = two_stop;

    serial_baud #(.DIV_W(DIV_W)) baud_i (
        .clk     (clk),
        .rst     (rst),
        .divisor (baud_div),
        .tick    (tick)
    );

    serial_tx #(.SUB_W(SUB_W)) tx_i (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .osr_last (osr_last),
        .cfg      (cfg),
        .wr       (tx_write),
        .wdata    ({tx_bit8, tx_data}),
        .txd      (txd),
        .empty    (tx_empty),
        .done     (tx_done)
    );

    serial_rx #(.SUB_W(SUB_W)) rx_i (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .osr_last (osr_last),
        .mid      (mid),
        .cfg      (cfg),
        .rxd      (rxd),
        .rd       (rx_read),
        .char_q   (rx_char),
        .done     (rx_full),
        .ovr      (overrun_err)
    );

    assign rx_data    = rx_char.data[7:0];
    assign rx_bit8    = rx_char.data[8];
    assign frame_err  = rx_char.frame_err;
    assign parity_err = rx_char.par_err;

    assign irq_rx    = rx_full  & irq_en_rx;
    assign irq_txc   = tx_done  & irq_en_txc;
    assign irq_empty = tx_empty & irq_en_empty;

    // R11: a disabled source never raises its interrupt
    assert_irq_gated_R11: assert property (@(posedge clk) disable iff (rst)
        (!irq_en_rx |-> !irq_rx) and (!irq_en_txc |-> !irq_txc) and (!irq_en_empty |-> !irq_empty));

endmodule

// File: tb/serial_xcvr_tb_top.sv
module serial_xcvr_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] baud_div = 12'd3;
    logic        fast_mode = 1'b0;
    logic [2:0]  size_code = 3'b011;
    logic [1:0]  par_mode = 2'b00;
    logic        two_stop = 1'b0;
    logic        irq_en_rx = 1'b0, irq_en_txc = 1'b0, irq_en_empty = 1'b0;
    logic        tx_write = 1'b0;
    logic [7:0]  tx_data = '0;
    logic        tx_bit8 = 1'b0;
    logic        rx_read = 1'b0;
    logic        rxd = 1'b1;
    logic        txd;
    logic [7:0]  rx_data;
    logic        rx_bit8, rx_full, tx_done, tx_empty;
    logic        frame_err, overrun_err, parity_err;
    logic        irq_rx, irq_txc, irq_empty;

    int checks = 0;
    int errors = 0;
    int T = 64;
    int frames_seen = 0;
    logic [8:0] tx_q[$];

    always #2.5 clk = ~clk;

    serial_xcvr dut_i (
        .clk(clk), .rst(rst), .baud_div(baud_div), .fast_mode(fast_mode),
        .size_code(size_code), .par_mode(par_mode), .two_stop(two_stop),
        .irq_en_rx(irq_en_rx), .irq_en_txc(irq_en_txc), .irq_en_empty(irq_en_empty),
        .tx_write(tx_write), .tx_data(tx_data), .tx_bit8(tx_bit8),
        .rx_read(rx_read), .rxd(rxd), .txd(txd), .rx_data(rx_data),
        .rx_bit8(rx_bit8), .rx_full(rx_full), .tx_done(tx_done),
        .tx_empty(tx_empty), .frame_err(frame_err), .overrun_err(overrun_err),
        .parity_err(parity_err), .irq_rx(irq_rx), .irq_txc(irq_txc),
        .irq_empty(irq_empty)
    );

    function automatic int nbits_of(input logic [2:0] c);
        case (c)
            3'b000: return 5;
            3'b001: return 6;
            3'b010: return 7;
            3'b111: return 9;
            default: return 8;
        endcase
    endfunction

    function automatic logic [8:0] mask_of(input int n);
        logic [8:0] m = '0;
        for (int i = 0; i < n; i++) m[i] = 1'b1;
        return m;
    endfunction

    function automatic logic ref_parity(input logic [8:0] d, input int n, input logic odd);
        logic p = odd;
        for (int i = 0; i < n; i++) p ^= d[i];
        return p;
    endfunction

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic set_cfg(input int div, input bit fast, input logic [2:0] sz,
                           input logic [1:0] pm, input bit two);
        @(negedge clk);
        baud_div = 12'(div); fast_mode = fast; size_code = sz; par_mode = pm; two_stop = two;
        T = (fast ? 8 : 16) * (div + 1);
        repeat (4) @(negedge clk);
    endtask

    // Driver: queue the expected character, then write it
    task automatic send_tx(input logic [8:0] d);
        while (!tx_empty) @(negedge clk);
        tx_data = d[7:0]; tx_bit8 = d[8]; tx_write = 1'b1;
        tx_q.push_back(d & mask_of(nbits_of(size_code)));
        @(negedge clk);
        tx_write = 1'b0;
    endtask

    task automatic tx_drain();
        while (tx_q.size() != 0) @(negedge clk);
        repeat (2 * T) @(negedge clk);
    endtask

    // Monitor: receives frames on txd and compares against the queue
    initial begin
        logic [8:0] got, exp;
        logic st, p, s1, s2;
        int n;
        forever begin
            @(negedge txd);
            if (rst) continue;
            n = nbits_of(size_code);
            got = '0; p = 1'b0; s2 = 1'b1;
            repeat (T / 2) @(posedge clk); #1;
            st = txd;
            for (int i = 0; i < n; i++) begin
                repeat (T) @(posedge clk); #1;
                got[i] = txd;
            end
            if (par_mode[1]) begin
                repeat (T) @(posedge clk); #1;
                p = txd;
            end
            repeat (T) @(posedge clk); #1;
            s1 = txd;
            if (two_stop) begin
                repeat (T) @(posedge clk); #1;
                s2 = txd;
            end
            frames_seen++;
            if (tx_q.size() == 0) begin
                chk("R6", "unexpected tx frame", 1, 0);
            end else begin
                exp = tx_q.pop_front();
                chk("R2", "tx start bit", st, 0);
                chk("R2", "tx data", got, exp);
                if (par_mode[1])
                    chk("R3", "tx parity bit", p, ref_parity(exp, n, par_mode[0]));
                chk("R4", "tx first stop", s1, 1);
                chk("R4", "tx second stop", s2, 1);
            end
        end
    end

    // Drives one frame on rxd with the current shape
    task automatic drive_rx(input logic [8:0] d, input bit bad_par,
                            input bit bad_stop1, input bit bad_stop2);
        int n = nbits_of(size_code);
        @(negedge clk);
        rxd = 1'b0; repeat (T) @(negedge clk);
        for (int i = 0; i < n; i++) begin
            rxd = d[i]; repeat (T) @(negedge clk);
        end
        if (par_mode[1]) begin
            rxd = ref_parity(d, n, par_mode[0]) ^ bad_par; repeat (T) @(negedge clk);
        end
        if (bad_stop1) begin
            rxd = 1'b0; repeat (5 * T / 8) @(negedge clk);
            rxd = 1'b1; repeat (T - 5 * T / 8) @(negedge clk);
        end else begin
            rxd = 1'b1; repeat (T) @(negedge clk);
        end
        if (two_stop) begin
            if (bad_stop2) begin
                rxd = 1'b0; repeat (3 * T / 8) @(negedge clk);
                rxd = 1'b1; repeat (T - 3 * T / 8) @(negedge clk);
            end else begin
                rxd = 1'b1; repeat (T) @(negedge clk);
            end
        end
        rxd = 1'b1; repeat (T) @(negedge clk);
    endtask

    task automatic do_read();
        @(negedge clk); rx_read = 1'b1;
        @(negedge clk); rx_read = 1'b0;
        @(negedge clk);
    endtask

    task automatic rx_expect(input string req, input logic [8:0] d, input bit fe, input bit pe);
        logic [8:0] m = d & mask_of(nbits_of(size_code));
        chk(req, "rx_full", rx_full, 1);
        chk(req, "rx_data", rx_data, m[7:0]);
        chk(req, "rx_bit8", rx_bit8, m[8]);
        chk(req, "frame_err", frame_err, fe);
        chk(req, "parity_err", parity_err, pe);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int base;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1", "txd idle", txd, 1);
        chk("R1", "tx_empty", tx_empty, 1);
        chk("R1", "rx_full", rx_full, 0);
        chk("R1", "tx_done", tx_done, 0);
        chk("R1", "errors", {frame_err, overrun_err, parity_err}, 0);
        chk("R1", "irqs", {irq_rx, irq_txc, irq_empty}, 0);

        // R2 / R6: 8N1, holding stage and ignored write
        set_cfg(3, 0, 3'b011, 2'b00, 0);
        base = frames_seen;
        tx_data = 8'hA5; tx_bit8 = 1'b0; tx_write = 1'b1; tx_q.push_back(9'h0A5);
        @(negedge clk); tx_write = 1'b0;
        chk("R6", "tx_empty after write", tx_empty, 0);
        @(negedge clk);
        chk("R6", "tx_empty after load", tx_empty, 1);
        chk("R2", "start bit on line", txd, 0);
        send_tx(9'h03C);
        tx_data = 8'hFF; tx_write = 1'b1;
        @(negedge clk); tx_write = 1'b0;
        tx_drain();
        chk("R6", "frames sent", frames_seen - base, 2);
        chk("R6", "tx_done after drain", tx_done, 1);
        irq_en_txc = 1'b1; irq_en_empty = 1'b1;
        @(negedge clk);
        chk("R11", "irq_txc", irq_txc, 1);
        chk("R11", "irq_empty", irq_empty, 1);
        send_tx(9'h081);
        chk("R6", "tx_done cleared by write", tx_done, 0);
        chk("R11", "irq_txc low", irq_txc, 0);
        irq_en_txc = 1'b0; irq_en_empty = 1'b0;
        tx_drain();

        // R3 / R4: 7 bits even parity two stops, 5 bits odd parity, reserved parity code
        set_cfg(3, 0, 3'b010, 2'b10, 1);
        send_tx(9'h055); send_tx(9'h07E);
        tx_drain();
        set_cfg(3, 0, 3'b000, 2'b11, 0);
        send_tx(9'h013); send_tx(9'h0FF);
        tx_drain();
        set_cfg(3, 0, 3'b011, 2'b01, 0);
        send_tx(9'h0C3);
        tx_drain();
        // R12: nine bits with ninth set
        set_cfg(3, 0, 3'b111, 2'b00, 0);
        send_tx(9'h1A6);
        tx_drain();
        // R5: double speed
        set_cfg(3, 1, 3'b011, 2'b10, 0);
        send_tx(9'h0B2);
        tx_drain();
        chk("R5", "all queued frames seen", tx_q.size(), 0);

        // R7 receive 8N1
        set_cfg(3, 0, 3'b011, 2'b00, 0);
        irq_en_rx = 1'b1;
        drive_rx(9'h05A, 0, 0, 0);
        rx_expect("R7", 9'h05A, 0, 0);
        chk("R11", "irq_rx", irq_rx, 1);
        do_read();
        chk("R7", "rx_full cleared", rx_full, 0);
        chk("R11", "irq_rx cleared", irq_rx, 0);
        irq_en_rx = 1'b0;

        // R9 parity on receive
        set_cfg(3, 0, 3'b010, 2'b10, 0);
        drive_rx(9'h055, 0, 0, 0);
        rx_expect("R9", 9'h055, 0, 0);
        do_read();
        drive_rx(9'h033, 1, 0, 0);
        rx_expect("R9", 9'h033, 0, 1);
        do_read();
        set_cfg(3, 0, 3'b011, 2'b11, 0);
        drive_rx(9'h0E1, 1, 0, 0);
        rx_expect("R9", 9'h0E1, 0, 1);
        do_read();

        // R4 framing error on first stop, second stop ignored
        set_cfg(3, 0, 3'b011, 2'b00, 1);
        drive_rx(9'h0C4, 0, 1, 0);
        rx_expect("R4", 9'h0C4, 1, 0);
        do_read();
        drive_rx(9'h017, 0, 0, 1);
        rx_expect("R4", 9'h017, 0, 0);
        do_read();
        chk("R4", "no extra char after low second stop", rx_full, 0);

        // R8 overrun
        set_cfg(3, 0, 3'b011, 2'b00, 0);
        drive_rx(9'h011, 0, 0, 0);
        drive_rx(9'h022, 0, 0, 0);
        chk("R8", "overrun_err", overrun_err, 1);
        chk("R8", "kept first char", rx_data, 8'h11);
        do_read();
        chk("R8", "overrun cleared", overrun_err, 0);

        // R10 glitch rejection
        @(negedge clk); rxd = 1'b0;
        repeat (T / 4) @(negedge clk);
        rxd = 1'b1;
        repeat (3 * T) @(negedge clk);
        chk("R10", "no char after glitch", rx_full, 0);
        drive_rx(9'h0A9, 0, 0, 0);
        rx_expect("R10", 9'h0A9, 0, 0);
        do_read();

        // R12 nine-bit receive, R5 double-speed receive
        set_cfg(3, 0, 3'b111, 2'b00, 0);
        drive_rx(9'h14B, 0, 0, 0);
        rx_expect("R12", 9'h14B, 0, 0);
        do_read();
        set_cfg(2, 1, 3'b011, 2'b00, 0);
        drive_rx(9'h0D6, 0, 0, 0);
        rx_expect("R5", 9'h0D6, 0, 0);
        do_read();

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule